// File: doc/BRIEF.md
# Per-Port Detection and Classification Sequencer with Cadence Back-Off

This block orders the discovery steps of a powered-Ethernet source, one sequencer per port. A start strobe launches load detection when the port's detection enable is set. It launches classification directly when only the classification enable is set. Classification follows a detection only after that detection has passed. The measurement front end reports results on result inputs. The sequencer answers with one-cycle launch pulses to the detection and classification engines and a one-cycle completion pulse.

A failed detection normally starts a fresh attempt at once. When the port's cadence bit is set, the port first waits a timed interval of about 2.2 s. That interval is counted in ticks of a shared prescaler: `TICK_DIV` clock cycles per tick and `BACKOFF_TICKS` ticks per wait. The per-port cadence bits sit in an 8-bit-readable register. Its reset value comes from two strap inputs.

Each sequencer has five states: `ST_IDLE`, `ST_DETECT`, `ST_CLASSIFY`, `ST_BACKOFF` and `ST_DONE`. Its transitions are:

- **launch-detect**: IDLE to DETECT on a start with detection enabled.
- **launch-classify**: IDLE to CLASSIFY on a start with only classification enabled.
- **empty-run**: IDLE to DONE on a start with neither enabled.
- **pass-to-classify**: DETECT to CLASSIFY.
- **pass-to-done**: DETECT to DONE.
- **retry**: DETECT to DETECT after a failure with cadence off.
- **fail-to-wait**: DETECT to BACKOFF.
- **wait-expired**: BACKOFF to DETECT, or to CLASSIFY if detection has been disabled since.
- **abort**: BACKOFF to IDLE when both enables are low.
- **class-finished**: CLASSIFY to DONE.
- **release**: DONE to IDLE.

Top module: `pse_seq_top`

## Requirements
- R1: While `rst_n` is low on a clock edge, every cadence bit n (bit n for port n+1) loads `midspan_pin & auto_pin`. Read bits above `NUM_PORTS-1` are 0. No pulse output is high after reset.
- R2: A cycle with `bko_wr` high stores `bko_wr_data` into the cadence bits. From the next cycle `bko_rd_data` returns them in bits 3:0, with bits 7:4 reading 0.
- R3: A start with detection enabled raises `det_start` for exactly one cycle, in the cycle after the start. This holds even if classification is also enabled, and no `cls_start` or `seq_done` is raised. Ports act independently.
- R4: A passing detection result with classification enabled raises `cls_start` in the next cycle, for one cycle. The next `cls_done` then raises `seq_done` in the following cycle.
- R5: A passing detection result with classification disabled raises `seq_done` in the next cycle, with no `cls_start`.
- R6: A start with detection disabled and classification enabled raises `cls_start` in the next cycle, with no `det_start`.
- R7: A failed detection with the port's cadence bit at 0 and detection still enabled raises `det_start` again in the next cycle, with no `cls_start`.
- R8: A failed detection with the cadence bit at 1 raises no pulse until the wait ends. The next `det_start` appears between (BACKOFF_TICKS-1)*TICK_DIV+2 and BACKOFF_TICKS*TICK_DIV+1 cycles after the result.
- R9: Dropping both enables during a wait returns the port to idle with no pulse. A later start is accepted.
- R10: `seq_done` lasts exactly one cycle. A start arriving while a port is busy has no effect.
- R11: A start with both enables low raises `seq_done` in the next cycle, with no launch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| midspan_pin | input | 1 | Strap, sampled during reset |
| auto_pin | input | 1 | Strap, sampled during reset |
| bko_wr | input | 1 | Cadence register write strobe |
| bko_wr_data | input | NUM_PORTS | Cadence bits to write |
| bko_rd_data | output | REG_W | Cadence register read value |
| det_en | input | NUM_PORTS | Per-port detection enable |
| cls_en | input | NUM_PORTS | Per-port classification enable |
| start | input | NUM_PORTS | Per-port start strobe |
| det_valid | input | NUM_PORTS | Detection result valid |
| det_pass | input | NUM_PORTS | Detection result, 1 = pass |
| cls_done | input | NUM_PORTS | Classification finished |
| det_start | output | NUM_PORTS | Detection launch pulse |
| cls_start | output | NUM_PORTS | Classification launch pulse |
| seq_done | output | NUM_PORTS | Sequence complete pulse |

## Verification
Launch and completion pulses are registered, so each is due exactly one cycle after the strobe or result that causes it. The bench drives inputs on the falling edge and samples at the next falling edge, one rising edge later. Register reads are due one cycle after the write.

The cadence wait alone has a spread, because the prescaler runs free. The bench therefore counts falling edges from the failed result to the next `det_start` and accepts the bounded window given in R8.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DETECT,
        ST_CLASSIFY,
        ST_BACKOFF,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/pse_tick_gen.sv
// Free-running prescaler: one-cycle tick every DIV clocks (DIV >= 2).
module pse_tick_gen #(
    parameter int unsigned DIV = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/pse_cadence_reg.sv
// Per-port cadence enable bits, strapped at reset, writable afterwards.
module pse_cadence_reg #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned REG_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_midspan,
    input  logic                 strap_auto,
    input  logic                 wr_en,
    input  logic [NUM_PORTS-1:0] wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [NUM_PORTS-1:0] bko_en
);
    logic [NUM_PORTS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= {NUM_PORTS{strap_midspan & strap_auto}};
        end else if (wr_en) begin
            bits_q <= wr_data;
        end
    end

    assign rd_data = REG_W'(bits_q);
    assign bko_en  = bits_q;

endmodule

// File: rtl/pse_port_seq.sv
// One port's detect / classify / back-off sequencer.
module pse_port_seq
    import pse_seq_pkg::*;
#(
    parameter int unsigned BACKOFF_TICKS = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic det_en,
    input  logic cls_en,
    input  logic bko_en,
    input  logic start,
    input  logic det_valid,
    input  logic det_pass,
    input  logic cls_done,
    output logic det_start,
    output logic cls_start,
    output logic seq_done
);
    localparam int unsigned CW = $clog2(BACKOFF_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(BACKOFF_TICKS - 1);

    seq_state_e    state_q, state_d;
    logic          launch_det, launch_cls, wait_clr;
    logic [CW-1:0] wait_q;

    // next-state and launch decisions
    always_comb begin
        state_d    = state_q;
        launch_det = 1'b0;
        launch_cls = 1'b0;
        wait_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (det_en) begin
                        state_d    = ST_DETECT;
                        launch_det = 1'b1;
                    end else if (cls_en) begin
                        state_d    = ST_CLASSIFY;
                        launch_cls = 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DETECT: begin
                if (det_valid) begin
                    if (det_pass) begin
                        if (cls_en) begin
                            state_d    = ST_CLASSIFY;
                            launch_cls = 1'b1;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end else if (bko_en) begin
                        state_d  = ST_BACKOFF;
                        wait_clr = 1'b1;
                    end else if (det_en) begin
                        state_d    = ST_DETECT;
                        launch_det = 1'b1;
                    end else if (cls_en) begin
                        state_d    = ST_CLASSIFY;
                        launch_cls = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BACKOFF: begin
                if (!det_en && !cls_en) begin
                    state_d = ST_IDLE;
                end else if (tick && wait_q == LAST) begin
                    if (det_en) begin
                        state_d    = ST_DETECT;
                        launch_det = 1'b1;
                    end else begin
                        state_d    = ST_CLASSIFY;
                        launch_cls = 1'b1;
                    end
                end
            end
            ST_CLASSIFY: begin
                if (cls_done) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // back-off tick counter
    always_ff @(posedge clk) begin
        if (!rst_n || wait_clr) begin
            wait_q <= '0;
        end else if (state_q == ST_BACKOFF && tick) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // registered output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_start <= 1'b0;
            cls_start <= 1'b0;
            seq_done  <= 1'b0;
        end else begin
            det_start <= launch_det;
            cls_start <= launch_cls;
            seq_done  <= (state_d == ST_DONE);
        end
    end

endmodule

// File: rtl/pse_seq_top.sv
module pse_seq_top
    import pse_seq_pkg::*;
#(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned REG_W         = 8,
    parameter int unsigned TICK_DIV      = 5_000_000,
    parameter int unsigned BACKOFF_TICKS = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 midspan_pin,
    input  logic                 auto_pin,
    input  logic                 bko_wr,
    input  logic [NUM_PORTS-1:0] bko_wr_data,
    output logic [REG_W-1:0]     bko_rd_data,
    input  logic [NUM_PORTS-1:0] det_en,
    input  logic [NUM_PORTS-1:0] cls_en,
    input  logic [NUM_PORTS-1:0] start,
    input  logic [NUM_PORTS-1:0] det_valid,
    input  logic [NUM_PORTS-1:0] det_pass,
    input  logic [NUM_PORTS-1:0] cls_done,
    output logic [NUM_PORTS-1:0] det_start,
    output logic [NUM_PORTS-1:0] cls_start,
    output logic [NUM_PORTS-1:0] seq_done
);
    logic                 tick;
    logic [NUM_PORTS-1:0] bko_en;

    pse_tick_gen #(
        .DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pse_cadence_reg #(
        .NUM_PORTS (NUM_PORTS),
        .REG_W     (REG_W)
    ) u_reg (
        .clk           (clk),
        .rst_n         (rst_n),
        .strap_midspan (midspan_pin),
        .strap_auto    (auto_pin),
        .wr_en         (bko_wr),
        .wr_data       (bko_wr_data),
        .rd_data       (bko_rd_data),
        .bko_en        (bko_en)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pse_port_seq #(
            .BACKOFF_TICKS (BACKOFF_TICKS)
        ) u_seq (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .det_en    (det_en[p]),
            .cls_en    (cls_en[p]),
            .bko_en    (bko_en[p]),
            .start     (start[p]),
            .det_valid (det_valid[p]),
            .det_pass  (det_pass[p]),
            .cls_done  (cls_done[p]),
            .det_start (det_start[p]),
            .cls_start (cls_start[p]),
            .seq_done  (seq_done[p])
        );
    end

endmodule

// File: rtl/pse_seq_chk.sv
module pse_seq_chk #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned REG_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 midspan_pin,
    input logic                 auto_pin,
    input logic                 bko_wr,
    input logic [NUM_PORTS-1:0] bko_wr_data,
    input logic [REG_W-1:0]     bko_rd_data,
    input logic [NUM_PORTS-1:0] det_start,
    input logic [NUM_PORTS-1:0] cls_start,
    input logic [NUM_PORTS-1:0] seq_done
);
    // R1
    strap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> bko_rd_data == REG_W'({NUM_PORTS{$past(midspan_pin & auto_pin)}}));

    // R2
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bko_wr)) |-> bko_rd_data == REG_W'($past(bko_wr_data)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R3
        pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({det_start[p], cls_start[p], seq_done[p]}));

        // R4
        cls_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cls_start[p] |=> !cls_start[p]);

        // R10
        done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seq_done[p] |=> !seq_done[p]);
    end

endmodule

bind pse_seq_top pse_seq_chk #(
    .NUM_PORTS (NUM_PORTS),
    .REG_W     (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .midspan_pin (midspan_pin),
    .auto_pin    (auto_pin),
    .bko_wr      (bko_wr),
    .bko_wr_data (bko_wr_data),
    .bko_rd_data (bko_rd_data),
    .det_start   (det_start),
    .cls_start   (cls_start),
    .seq_done    (seq_done)
);

// File: tb/sim_pse_seq_top.sv
module sim_pse_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int RW   = 8;
    localparam int DIV  = 4;
    localparam int TCKS = 5;
    localparam int WIN_LO = (TCKS - 1) * DIV + 2;
    localparam int WIN_HI = TCKS * DIV + 1;

    // pulse codes: 0 none, 1 det_start, 2 cls_start, 3 seq_done, 7 illegal mix
    typedef struct packed {
        logic       d;
        logic       c;
        logic       pass;
        logic       bko;
        logic [1:0] e1;
        logic [1:0] e2;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2},   // R3 R4
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd3},   // R5
        '{1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0},   // R6
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0},   // R11
        '{1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd1},   // R7
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0},   // R8
        '{1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 2'd0}    // R8
    };
    string vec_req [7] = '{"R3/R4", "R5", "R6", "R11", "R7", "R8", "R8"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          midspan_pin = 1'b1;
    logic          auto_pin = 1'b1;
    logic          bko_wr = 1'b0;
    logic [NP-1:0] bko_wr_data = '0;
    logic [RW-1:0] bko_rd_data;
    logic [NP-1:0] det_en = '0;
    logic [NP-1:0] cls_en = '0;
    logic [NP-1:0] start = '0;
    logic [NP-1:0] det_valid = '0;
    logic [NP-1:0] det_pass = '0;
    logic [NP-1:0] cls_done = '0;
    logic [NP-1:0] det_start, cls_start, seq_done;

    int vectors = 0;
    int misses  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pse_seq_top #(
        .NUM_PORTS     (NP),
        .REG_W         (RW),
        .TICK_DIV      (DIV),
        .BACKOFF_TICKS (TCKS)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .midspan_pin (midspan_pin),
        .auto_pin    (auto_pin),
        .bko_wr      (bko_wr),
        .bko_wr_data (bko_wr_data),
        .bko_rd_data (bko_rd_data),
        .det_en      (det_en),
        .cls_en      (cls_en),
        .start       (start),
        .det_valid   (det_valid),
        .det_pass    (det_pass),
        .cls_done    (cls_done),
        .det_start   (det_start),
        .cls_start   (cls_start),
        .seq_done    (seq_done)
    );

    function automatic int pcode(int p);
        logic [2:0] b;
        b = {det_start[p], cls_start[p], seq_done[p]};
        case (b)
            3'b000:  return 0;
            3'b100:  return 1;
            3'b010:  return 2;
            3'b001:  return 3;
            default: return 7;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(logic [NP-1:0] val);
        bko_wr = 1'b1;
        bko_wr_data = val;
        @(negedge clk);
        bko_wr = 1'b0;
    endtask

    task automatic pulse_start(int p);
        start[p] = 1'b1;
        @(negedge clk);
        start[p] = 1'b0;
    endtask

    task automatic det_result(int p, logic pass);
        det_valid[p] = 1'b1;
        det_pass[p]  = pass;
        @(negedge clk);
        det_valid[p] = 1'b0;
        det_pass[p]  = 1'b0;
    endtask

    task automatic cls_finish(int p);
        cls_done[p] = 1'b1;
        @(negedge clk);
        cls_done[p] = 1'b0;
    endtask

    task automatic to_idle(int p);
        det_en[p] = 1'b0;
        cls_en[p] = 1'b0;
        det_result(p, 1'b0);
        tick_n(3);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int k;
        int seen;
        tick_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state with both straps high
        check("R1 rd", int'(bko_rd_data), 8'h0F);
        for (int p = 0; p < NP; p++) check("R1 pulses", pcode(p), 0);

        // R2: write and read back, upper bits zero
        write_reg(4'b1010);
        check("R2 rd", int'(bko_rd_data), 8'h0A);
        write_reg(4'b0101);
        check("R2 rd", int'(bko_rd_data), 8'h05);

        // vector table on port 0
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            logic done_seen;
            v = VECS[i];
            done_seen = 1'b0;
            write_reg({3'b000, v.bko});
            det_en[0] = v.d;
            cls_en[0] = v.c;
            pulse_start(0);
            check(vec_req[i], pcode(0), int'(v.e1));
            if (v.e1 == 2'd3) done_seen = 1'b1;
            if (v.e1 == 2'd1) begin
                det_result(0, v.pass);
                check(vec_req[i], pcode(0), int'(v.e2));
                if (v.e2 == 2'd3) done_seen = 1'b1;
                if (v.e2 == 2'd2) begin
                    cls_finish(0);
                    check("R4 done", pcode(0), 3);
                    done_seen = 1'b1;
                end
            end else if (v.e1 == 2'd2) begin
                cls_finish(0);
                check("R6 done", pcode(0), 3);
                done_seen = 1'b1;
            end
            if (done_seen) begin
                @(negedge clk);
                check("R10 one cycle", pcode(0), 0);
            end
            to_idle(0);
        end

        // R8: back-off window
        write_reg(4'b0001);
        det_en[0] = 1'b1;
        pulse_start(0);
        check("R8 launch", pcode(0), 1);
        det_result(0, 1'b0);
        k = 1;
        seen = 0;
        while (k <= WIN_HI + 5 && pcode(0) != 1) begin
            if (pcode(0) != 0) seen++;
            @(negedge clk);
            k++;
        end
        vectors++;
        if (k < WIN_LO || k > WIN_HI) begin
            misses++;
            $display("FAIL R8 wait: got %0d expected %0d..%0d", k, WIN_LO, WIN_HI);
        end
        check("R8 quiet during wait", seen, 0);
        det_result(0, 1'b1);
        check("R5 after retry", pcode(0), 3);
        tick_n(2);

        // R9: abort back-off
        det_en[0] = 1'b1;
        pulse_start(0);
        det_result(0, 1'b0);
        tick_n(3);
        det_en[0] = 1'b0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pcode(0) != 0) seen++;
        end
        check("R9 no pulse after abort", seen, 0);
        det_en[0] = 1'b1;
        pulse_start(0);
        check("R9 restart", pcode(0), 1);

        // R10: start while busy ignored
        pulse_start(0);
        check("R10 busy start", pcode(0), 0);
        det_result(0, 1'b1);
        check("R10 done", pcode(0), 3);
        @(negedge clk);
        check("R10 one cycle", pcode(0), 0);
        write_reg(4'b0000);
        to_idle(0);

        // R3: port independence
        det_en[2] = 1'b1;
        cls_en[2] = 1'b1;
        pulse_start(2);
        check("R3 port2", pcode(2), 1);
        check("R3 port0 quiet", pcode(0), 0);
        check("R3 port1 quiet", pcode(1), 0);
        to_idle(2);

        // R1: reset with AUTO low
        rst_n = 1'b0;
        auto_pin = 1'b0;
        tick_n(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd auto low", int'(bko_rd_data), 8'h00);

        summary();
        $finish;
    end

endmodule